// File: doc/BRIEF.md
# Multiplexed Display Refresh Controller

This block keeps one 8-bit segment word for each digit of a multiplexed display, up to sixteen digits, in a small internal RAM. It shows the digits one after another. A scan strobe from a shared timebase steps the sequencer. Each digit slot lasts two strobes. During the first strobe the display is blanked. During the second strobe the word for that digit is shown. The current digit index is driven out so that the digit drivers, and any other user of the scan count, can follow it.

The host reaches the RAM through a pointer register. The host can load the pointer, write a word, or read a word back. Each write or read moves the pointer up by one. Refresh keeps running while the host works. The RAM has a single access port, so a host access takes that port for the cycle. In that cycle the refresh side holds the word it last latched. The latched word leaves the block as two 4-bit groups. Segment decoding and the physical digit drivers are outside this block.

Top module: `seg_mux_ctrl`

## Requirements
- R1: After reset, blank is 1, digit is 0, seg_a, seg_b and host_rdata are 0, the pointer is 0 and every RAM word is 0.
- R2: When host_wr is 1 and host_ptr_ld is 0, host_wdata is stored at the pointer location. The pointer then moves up by one and wraps from DEPTH-1 to 0.
- R3: When host_rd is 1 and both host_wr and host_ptr_ld are 0, host_rdata shows the word at the pointer one cycle later. The pointer moves up by one, and host_rdata holds its value until the next such read.
- R4: When host_ptr_ld is 1, the pointer takes host_ptr_val. Any host_wr or host_rd in that same cycle is ignored.
- R5: When host_wr and host_rd are both 1 in the same cycle, only the write takes place. host_rdata keeps its value and the pointer moves up by exactly one.
- R6: Each scan_tick toggles the phase. The phase is blanked (blank=1) or shown (blank=0). A tick that ends a shown phase also moves digit to the next index, and digit wraps from NUM_DIGITS-1 to 0.
- R7: In a cycle without a host write or read, the refresh latch takes the RAM word at digit. One cycle later, seg_a shows bits 7:4 of that word and seg_b shows bits 3:0.
- R8: In a cycle with a host write or read, the refresh latch keeps its previous value, so seg_a and seg_b do not change on the following edge.
- R9: Without scan_tick, blank and digit keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| scan_tick | input | 1 | One-cycle strobe from the shared scan timebase |
| host_ptr_ld | input | 1 | Load the pointer |
| host_ptr_val | input | 4 | Pointer value to load |
| host_wr | input | 1 | Write host_wdata at the pointer |
| host_rd | input | 1 | Read the word at the pointer |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data, registered |
| digit | output | 4 | Current digit index (scan count) |
| blank | output | 1 | Display off while high |
| seg_a | output | 4 | Upper nibble of the latched segment word |
| seg_b | output | 4 | Lower nibble of the latched segment word |

## Verification
A host write or read and the refresh fetch can both need the single RAM port in the same cycle. The bench provokes this by issuing random host operations in most cycles while scan ticks keep arriving, so that host accesses often fall in the cycle just after a digit change. For every cycle, a bench model predicts whether the refresh latch took the word at the current digit or kept its old value. It compares seg_a and seg_b against that prediction. Mismatches are tagged R8 when the preceding cycle held a host access and R7 when it did not. The same mixed traffic also checks that the host's read data and pointer movement stay correct while the refresh side is held back.

// File: rtl/seg_mux_pkg.sv
package seg_mux_pkg;

  // Advance an index by one, returning to zero at the limit.
  function automatic int unsigned step_wrap(input int unsigned v, input int unsigned lim);
    return (v + 1 >= lim) ? 0 : v + 1;
  endfunction

  // Host port arbitration: pointer load beats write, write beats read.
  function automatic logic host_do_wr(input logic ld, input logic wr);
    return wr & ~ld;
  endfunction

  function automatic logic host_do_rd(input logic ld, input logic wr, input logic rd);
    return rd & ~wr & ~ld;
  endfunction

endpackage

// File: rtl/scan_seq.sv
module scan_seq
  import seg_mux_pkg::*;
#(
  parameter int NUM_DIGITS = 16,
  parameter int IW         = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  output logic [IW-1:0] digit,
  output logic          shown,
  output logic          digit_adv
);

  assign digit_adv = tick & shown;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      digit <= '0;
      shown <= 1'b0;
    end else if (tick) begin
      shown <= ~shown;
      if (shown) digit <= IW'(step_wrap(int'(digit), NUM_DIGITS));
    end
  end

  // R6: every tick flips the phase
  p_phase_flip_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (shown != $past(shown)));

  // R6: a digit change always lands in a blanked phase on the next index
  p_adv_blanks_r6: assert property (@(posedge clk) disable iff (!rst_n)
    digit_adv |=> (!shown && digit == IW'(step_wrap(int'($past(digit)), NUM_DIGITS))));

  // R9: no tick means no movement
  p_idle_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> ($stable(shown) && $stable(digit)));

endmodule

// File: rtl/disp_ram.sv
module disp_ram
  import seg_mux_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  parameter int AW    = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ptr_ld,
  input  logic [AW-1:0] ptr_val,
  input  logic          wr,
  input  logic          rd,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] scan_addr,
  output logic [DW-1:0] rdata,
  output logic [DW-1:0] port_q,
  output logic          host_busy
);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] ptr;
  logic          do_wr, do_rd;
  logic [AW-1:0] port_addr;

  assign do_wr     = host_do_wr(ptr_ld, wr);
  assign do_rd     = host_do_rd(ptr_ld, wr, rd);
  assign host_busy = do_wr | do_rd;
  // Single access port: the host wins it whenever it needs it.
  assign port_addr = host_busy ? ptr : scan_addr;
  assign port_q    = mem[port_addr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      ptr   <= '0;
      rdata <= '0;
    end else begin
      if (do_wr) mem[ptr] <= wdata;
      if (do_rd) rdata <= port_q;
      if (ptr_ld)         ptr <= ptr_val;
      else if (host_busy) ptr <= AW'(step_wrap(int'(ptr), DEPTH));
    end
  end

  // R2/R3: each accepted access moves the pointer by one
  p_ptr_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    host_busy |=> (ptr == AW'(step_wrap(int'($past(ptr)), DEPTH))));

  // R4: a load sets the pointer exactly
  p_ptr_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_ld |=> (ptr == $past(ptr_val)));

  // R3/R5: read data changes only after an accepted read
  p_rdata_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !do_rd |=> $stable(rdata));

  // R5: write and read together never both proceed
  p_one_access_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({do_wr, do_rd}) <= 1);

endmodule

// File: rtl/seg_mux_ctrl.sv
module seg_mux_ctrl #(
  parameter int NUM_DIGITS = 16,
  parameter int DEPTH      = 16,
  parameter int DW         = 8,
  localparam int AW        = $clog2(DEPTH),
  localparam int NW        = DW / 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scan_tick,
  input  logic          host_ptr_ld,
  input  logic [AW-1:0] host_ptr_val,
  input  logic          host_wr,
  input  logic          host_rd,
  input  logic [DW-1:0] host_wdata,
  output logic [DW-1:0] host_rdata,
  output logic [AW-1:0] digit,
  output logic          blank,
  output logic [NW-1:0] seg_a,
  output logic [NW-1:0] seg_b
);

  logic          shown;
  logic          digit_adv;
  logic [DW-1:0] port_q;
  logic          host_busy;
  logic          refresh_take;
  logic [DW-1:0] seg_q;

  scan_seq #(.NUM_DIGITS(NUM_DIGITS), .IW(AW)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (scan_tick),
    .digit     (digit),
    .shown     (shown),
    .digit_adv (digit_adv)
  );

  disp_ram #(.DEPTH(DEPTH), .DW(DW), .AW(AW)) u_ram (
    .clk       (clk),
    .rst_n     (rst_n),
    .ptr_ld    (host_ptr_ld),
    .ptr_val   (host_ptr_val),
    .wr        (host_wr),
    .rd        (host_rd),
    .wdata     (host_wdata),
    .scan_addr (digit),
    .rdata     (host_rdata),
    .port_q    (port_q),
    .host_busy (host_busy)
  );

  assign refresh_take = ~host_busy;

  always_ff @(posedge clk) begin
    if (!rst_n)            seg_q <= '0;
    else if (refresh_take) seg_q <= port_q;
  end

  assign blank = ~shown;
  assign seg_a = seg_q[DW-1:NW];
  assign seg_b = seg_q[NW-1:0];

  // R8: a host access freezes the displayed word
  p_hold_on_host_r8: assert property (@(posedge clk) disable iff (!rst_n)
    host_busy |=> $stable(seg_q));

  // R6: the digit index never moves while the display is lit
  p_digit_under_blank_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (digit != $past(digit)) |-> blank);

endmodule

// File: tb/sim_seg_mux_ctrl.sv
module sim_seg_mux_ctrl;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       scan_tick, host_ptr_ld, host_wr, host_rd;
  logic [3:0] host_ptr_val;
  logic [7:0] host_wdata;
  logic [7:0] host_rdata;
  logic [3:0] digit, seg_a, seg_b;
  logic       blank;

  always #10 clk = ~clk;

  seg_mux_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .scan_tick(scan_tick),
    .host_ptr_ld(host_ptr_ld), .host_ptr_val(host_ptr_val),
    .host_wr(host_wr), .host_rd(host_rd), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .digit(digit), .blank(blank),
    .seg_a(seg_a), .seg_b(seg_b)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  string rd_tag = "R3";

  logic [7:0] m_mem [16];
  int         m_ptr, m_dig;
  bit         m_shown, m_last_busy, m_last_tick;
  logic [7:0] m_seg, m_rd;

  function automatic int nxt(input int v, input int lim);
    return (v == lim - 1) ? 0 : v + 1;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic compare_all();
    chk(m_last_tick ? "R6" : "R9", {digit, blank}, {m_dig[3:0], ~m_shown});
    chk(m_last_busy ? "R8" : "R7", {seg_a, seg_b}, m_seg);
    chk(rd_tag, host_rdata, m_rd);
  endtask

  task automatic step(input bit ld, input int pv, input bit wr, input bit rd,
                      input int wd, input bit tk);
    bit dw, dr;
    host_ptr_ld = ld; host_ptr_val = pv[3:0]; host_wr = wr; host_rd = rd;
    host_wdata = wd[7:0]; scan_tick = tk;
    @(posedge clk);
    dw = wr && !ld;
    dr = rd && !wr && !ld;
    if (!(dw || dr)) m_seg = m_mem[m_dig];
    if (dr) m_rd = m_mem[m_ptr];
    if (dw) m_mem[m_ptr] = wd[7:0];
    if (ld) m_ptr = pv;
    else if (dw || dr) m_ptr = nxt(m_ptr, 16);
    if (tk) begin
      if (m_shown) m_dig = nxt(m_dig, 16);
      m_shown = !m_shown;
    end
    m_last_busy = dw || dr;
    m_last_tick = tk;
    @(negedge clk);
    compare_all();
  endtask

  initial begin
    int unsigned seed = 32'd1234;
    void'($urandom(seed));
    rst_n = 1'b0;
    scan_tick = 0; host_ptr_ld = 0; host_ptr_val = 0;
    host_wr = 0; host_rd = 0; host_wdata = 0;
    for (int i = 0; i < 16; i++) m_mem[i] = 8'h00;
    m_ptr = 0; m_dig = 0; m_shown = 0; m_seg = 0; m_rd = 0;
    m_last_busy = 0; m_last_tick = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    chk("R1", {digit, blank}, {4'd0, 1'b1});
    chk("R1", {seg_a, seg_b}, 8'h00);
    chk("R1", host_rdata, 8'h00);
    rd_tag = "R1";
    step(0, 0, 0, 1, 0, 0);   // read location 0 at reset pointer

    // R2: 20 writes wrap the pointer, then read all back
    rd_tag = "R2";
    step(1, 0, 0, 0, 0, 0);
    for (int i = 0; i < 20; i++) step(0, 0, 1, 0, i * 7 + 3, i % 3 == 0);
    step(1, 0, 0, 0, 0, 0);
    for (int i = 0; i < 17; i++) step(0, 0, 0, 1, 0, 0);

    // R4: load beats write and read in the same cycle
    rd_tag = "R4";
    step(1, 5, 1, 1, 8'hFF, 0);
    step(0, 0, 0, 1, 0, 0);
    step(0, 0, 0, 1, 0, 0);

    // R5: write and read together, then read back
    rd_tag = "R5";
    step(1, 9, 0, 0, 0, 0);
    step(0, 0, 1, 1, 8'hA5, 0);
    step(1, 9, 0, 0, 0, 0);
    step(0, 0, 0, 1, 0, 0);

    // R9: no ticks for a while
    for (int i = 0; i < 10; i++) step(0, 0, 0, 0, 0, 0);

    // R7/R8: collisions right after ticks
    rd_tag = "R3";
    for (int i = 0; i < 40; i++) begin
      step(0, 0, 0, 0, 0, 1);
      step(0, 0, (i % 2) == 0, (i % 2) == 1, i * 13, 0);
    end

    // R3/R6/R7/R8: constrained random mix
    for (int i = 0; i < 3000; i++) begin
      int unsigned r = $urandom % 100;
      step(r < 4, $urandom % 16, (r >= 4 && r < 30) || r >= 95,
           r >= 30 && r < 55 || r >= 90, $urandom % 256, ($urandom % 4) == 0);
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule